// File: doc/BRIEF.md
# I2C Bit Clock and Data Edge Timer

This block paces single bits on an I2C bus for a master. A byte sequencer asks for one bit at a time with a one-cycle request and the bit value. The block then drives SCL low, waits a data hold delay, and puts the bit on SDA. After a data setup delay and the programmed low period, it releases SCL. Once the filtered SCL line is seen high, it counts the high period, samples SDA at the start of that high period, and drives SCL low again to end the bit. All delays come from one packed 32-bit timing word that has a shared 4-bit clock divider.

Both bus inputs pass through a two-stage synchronizer and then a digital glitch filter. The filter's length runs from 0 to 16 kernel clocks. Each low or high period starts only when the filtered SCL level shows that the bus really changed. Because of this, a slave that holds SCL low after release stretches the bit. The block flags a stretch when the wait after release lasts longer than the synchronizer and filter alone can explain. The timing word and the filter length are taken only while the block is disabled.

Top module: `i2c_bit_timer`

## Requirements
- R1: The timing word fields are: divider bits 31:28 (d), setup bits 23:20 (s), hold bits 19:16 (h), high period bits 15:8 (H), and low period bits 7:0 (L). Bits 27:24 are ignored. The word and `filt_len` are captured on every cycle while `enable` is low. A change while `enable` is high has no effect until the block is disabled and enabled again.
- R2: Counting starts from the first cycle in which the filtered SCL level is low. SCL is driven low (`scl_drive_low`=1) for max((L+1)(d+1), hold span + setup span) kernel clocks.
- R3: The hold span is h*(d+1)+1 kernel clocks after the low count starts. After it, `sda_drive_low` takes the inverse of the requested bit: 1 drives SDA low for a 0 bit.
- R4: SCL is released no sooner than (s+1)(d+1) kernel clocks after SDA is updated. This is the setup span.
- R5: When the bus is not stretched, SCL stays released for 3+m+(H+1)(d+1) kernel clocks. Here m = max(f,1), and f is `filt_len` clamped to 16.
- R6: The glitch filter accepts a new line level only after the synchronized input has differed from the accepted level for f kernel clocks. With f=0 the filter is bypassed, leaving a single register.
- R7: The high count waits until the filtered SCL is high. If the line is held low for X cycles after release, the high phase starts X cycles later. `stretch_seen` is high only while that wait is longer than m+2 cycles.
- R8: `rx_sample` is a one-cycle pulse in the first cycle of the high period. In that same cycle, `rx_bit` shows the filtered SDA level.
- R9: `bit_done` pulses for one cycle when SCL is driven low again at the end of the high period. SCL then stays driven low until the next request.
- R10: After reset, and whenever `enable` is low, both lines are released and no pulse output is active.
- R11: A `bit_go` request that arrives while a bit is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low captures configuration |
| timing_word | input | 32 | Packed timing fields |
| filt_len | input | 5 | Glitch filter length in kernel clocks (clamped to 16) |
| bit_go | input | 1 | One-cycle request to send or receive one bit |
| tx_bit | input | 1 | Bit value to place on SDA, captured with the request |
| scl_in | input | 1 | Observed SCL line level |
| sda_in | input | 1 | Observed SDA line level |
| scl_drive_low | output | 1 | Open-drain enable pulling SCL low |
| sda_drive_low | output | 1 | Open-drain enable pulling SDA low |
| rx_sample | output | 1 | Strobe at start of SCL high period |
| rx_bit | output | 1 | Filtered SDA level captured with the strobe |
| bit_done | output | 1 | Pulse when the bit period ends |
| stretch_seen | output | 1 | Release wait exceeds the expected settle delay |

## Verification
The assertions assume SDA changes only while SCL is driven low, and they assume no slave pulls SCL low during a high period that has already begun. The bench models the bus as wired-AND lines. It lets the slave hold SCL only between release and the start of the high period, and it changes the slave's SDA pull only before a bit is requested. Configuration words are changed only when the block is idle, so every span the assertions rely on starts from a settled filter.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

    localparam int CNT_W   = 13;
    localparam int FLT_W   = 5;
    localparam int FLT_MAX = 16;
    localparam int SCNT_W  = 8;

    typedef struct packed {
        logic [3:0] div;
        logic [3:0] spare;
        logic [3:0] su;
        logic [3:0] hd;
        logic [7:0] hi;
        logic [7:0] lo;
    } tword_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_FALL, PH_LOW, PH_RISE, PH_HIGH
    } phase_t;

    typedef enum logic [1:0] {
        DS_HOLD, DS_SETUP, DS_DONE
    } dsub_t;

    function automatic logic [CNT_W-1:0] scaled(input logic [7:0] f, input logic [3:0] div);
        logic [CNT_W-1:0] a;
        logic [CNT_W-1:0] b;
        a = CNT_W'(f) + CNT_W'(1);
        b = CNT_W'(div) + CNT_W'(1);
        return a * b;
    endfunction

    function automatic logic [CNT_W-1:0] hold_span(input logic [3:0] hd, input logic [3:0] div);
        logic [CNT_W-1:0] b;
        b = CNT_W'(div) + CNT_W'(1);
        return CNT_W'(hd) * b + CNT_W'(1);
    endfunction

    function automatic logic [FLT_W-1:0] flt_clamp(input logic [FLT_W-1:0] len);
        return (len > FLT_W'(FLT_MAX)) ? FLT_W'(FLT_MAX) : len;
    endfunction

endpackage

// File: rtl/i2c_bt_glitch.sv
module i2c_bt_glitch
    import i2c_bt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LEN_W       = FLT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    input  logic [LEN_W-1:0] len,
    output logic             level_out
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [LEN_W-1:0]       run_q;
    logic                   raw;

    assign raw = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= '1;
            run_q     <= '0;
            level_out <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            if (len == '0) begin
                level_out <= raw;
                run_q     <= '0;
            end else if (raw == level_out) begin
                run_q <= '0;
            end else if (run_q == len - LEN_W'(1)) begin
                level_out <= raw;
                run_q     <= '0;
            end else begin
                run_q <= run_q + LEN_W'(1);
            end
        end
    end

    // R6
    flt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_out) |-> level_out == $past(raw));

endmodule

// File: rtl/i2c_bt_cfg.sv
module i2c_bt_cfg
    import i2c_bt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int FW = FLT_W,
    parameter int SW = SCNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [31:0]   timing_word,
    input  logic [FW-1:0] filt_len,
    output logic [CW-1:0] low_clks,
    output logic [CW-1:0] high_clks,
    output logic [CW-1:0] hold_clks,
    output logic [CW-1:0] setup_clks,
    output logic [FW-1:0] flt_len,
    output logic [SW-1:0] settle_lim
);
    logic [31:0]   word_q;
    logic [FW-1:0] len_q;
    tword_t        tw;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            len_q  <= '0;
        end else if (!enable) begin
            word_q <= timing_word;
            len_q  <= flt_clamp(filt_len);
        end
    end

    assign tw         = tword_t'(word_q);
    assign low_clks   = scaled(tw.lo, tw.div);
    assign high_clks  = scaled(tw.hi, tw.div);
    assign setup_clks = scaled({4'b0, tw.su}, tw.div);
    assign hold_clks  = hold_span(tw.hd, tw.div);
    assign flt_len    = len_q;
    assign settle_lim = SW'((len_q == '0) ? FW'(1) : len_q) + SW'(2);

    // R1
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable)) |-> ($stable(word_q) && $stable(len_q)));

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
    import i2c_bt_pkg::*;
#(
    parameter int CW          = CNT_W,
    parameter int FW          = FLT_W,
    parameter int SW          = SCNT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [31:0]   timing_word,
    input  logic [FW-1:0] filt_len,
    input  logic          bit_go,
    input  logic          tx_bit,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_drive_low,
    output logic          sda_drive_low,
    output logic          rx_sample,
    output logic          rx_bit,
    output logic          bit_done,
    output logic          stretch_seen
);
    localparam int NLINES = 2;

    logic [CW-1:0] low_clks, high_clks, hold_clks, setup_clks;
    logic [FW-1:0] flt_len;
    logic [SW-1:0] settle_lim;

    i2c_bt_cfg #(.CW(CW), .FW(FW), .SW(SW)) u_cfg (
        .clk, .rst, .enable, .timing_word, .filt_len,
        .low_clks, .high_clks, .hold_clks, .setup_clks,
        .flt_len, .settle_lim
    );

    logic [NLINES-1:0] line_raw, line_f;
    assign line_raw = {sda_in, scl_in};

    for (genvar i = 0; i < NLINES; i++) begin : g_flt
        i2c_bt_glitch #(.SYNC_STAGES(SYNC_STAGES), .LEN_W(FW)) u_flt (
            .clk, .rst,
            .line_in   (line_raw[i]),
            .len       (flt_len),
            .level_out (line_f[i])
        );
    end

    logic scl_f, sda_f;
    assign scl_f = line_f[0];
    assign sda_f = line_f[1];

    phase_t        phase;
    dsub_t         dsub;
    logic [CW-1:0] cnt_a, cnt_b;
    logic [SW-1:0] sync_cnt;
    logic          hold_low, tx_q, setup_ok;

    assign setup_ok = (dsub == DS_DONE) || (dsub == DS_SETUP && cnt_b == '0);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase         <= PH_IDLE;
            dsub          <= DS_HOLD;
            cnt_a         <= '0;
            cnt_b         <= '0;
            sync_cnt      <= '0;
            hold_low      <= 1'b0;
            tx_q          <= 1'b1;
            sda_drive_low <= 1'b0;
            rx_sample     <= 1'b0;
            rx_bit        <= 1'b1;
            bit_done      <= 1'b0;
        end else begin
            rx_sample <= 1'b0;
            bit_done  <= 1'b0;
            case (phase)
                PH_IDLE: if (bit_go) begin
                    tx_q  <= tx_bit;
                    phase <= PH_FALL;
                end
                PH_FALL: if (!scl_f) begin
                    phase <= PH_LOW;
                    cnt_a <= low_clks - CW'(1);
                    cnt_b <= hold_clks - CW'(1);
                    dsub  <= DS_HOLD;
                end
                PH_LOW: begin
                    if (cnt_a != '0) cnt_a <= cnt_a - CW'(1);
                    case (dsub)
                        DS_HOLD: if (cnt_b == '0) begin
                            sda_drive_low <= ~tx_q;
                            cnt_b         <= setup_clks - CW'(1);
                            dsub          <= DS_SETUP;
                        end else cnt_b <= cnt_b - CW'(1);
                        DS_SETUP: if (cnt_b == '0) dsub <= DS_DONE;
                                  else cnt_b <= cnt_b - CW'(1);
                        default: ;
                    endcase
                    if (cnt_a == '0 && setup_ok) begin
                        phase    <= PH_RISE;
                        sync_cnt <= '0;
                    end
                end
                PH_RISE: if (scl_f) begin
                    phase     <= PH_HIGH;
                    cnt_a     <= high_clks - CW'(1);
                    rx_sample <= 1'b1;
                    rx_bit    <= sda_f;
                end else if (sync_cnt != '1) begin
                    sync_cnt <= sync_cnt + SW'(1);
                end
                PH_HIGH: if (cnt_a == '0) begin
                    phase    <= PH_IDLE;
                    hold_low <= 1'b1;
                    bit_done <= 1'b1;
                end else cnt_a <= cnt_a - CW'(1);
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign scl_drive_low = (phase == PH_FALL) || (phase == PH_LOW) ||
                           (phase == PH_IDLE && hold_low);
    assign stretch_seen  = (phase == PH_RISE) && (sync_cnt > settle_lim);

    // R3
    sda_in_low_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && !$stable(sda_drive_low)) |-> scl_drive_low);
    // R8
    sample_released_chk: assert property (@(posedge clk) disable iff (rst)
        rx_sample |-> !scl_drive_low);
    // R8
    sample_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_sample |=> !rx_sample);
    // R9
    done_drives_chk: assert property (@(posedge clk) disable iff (rst)
        bit_done |-> scl_drive_low);
    // R7
    stretch_released_chk: assert property (@(posedge clk) disable iff (rst)
        stretch_seen |-> (!scl_drive_low && !rx_sample));
    // R10
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> (!scl_drive_low && !sda_drive_low && !bit_done && !rx_sample));

endmodule

// File: tb/i2c_bit_timer_test.sv
module i2c_bit_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [31:0] timing_word = '0;
    logic [4:0]  filt_len = '0;
    logic        bit_go = 1'b0;
    logic        tx_bit = 1'b1;
    logic        slave_scl_low = 1'b0;
    logic        slave_sda_low = 1'b0;
    logic        scl_in, sda_in;
    logic        scl_drive_low, sda_drive_low, rx_sample, rx_bit, bit_done, stretch_seen;

    int tests = 0;
    int fails = 0;
    bit last_tx = 1'b1;

    always #10 clk = ~clk;

    assign scl_in = ~(scl_drive_low | slave_scl_low);
    assign sda_in = ~(sda_drive_low | slave_sda_low);

    i2c_bit_timer uut (
        .clk, .rst, .enable, .timing_word, .filt_len, .bit_go, .tx_bit,
        .scl_in, .sda_in, .scl_drive_low, .sda_drive_low, .rx_sample,
        .rx_bit, .bit_done, .stretch_seen
    );

    function automatic int f_low(int lo, int d);  return (lo + 1) * (d + 1); endfunction
    function automatic int f_hold(int h, int d);  return h * (d + 1) + 1;    endfunction
    function automatic int f_m(int c);            return (c == 0) ? 1 : ((c > 16) ? 16 : c); endfunction
    function automatic int f_max(int a, int b);   return (a > b) ? a : b; endfunction
    function automatic logic [31:0] f_pack(int d, int s, int h, int hi, int lo, int junk);
        return {4'(d), 4'(junk), 4'(s), 4'(h), 8'(hi), 8'(lo)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // disable, load, enable, then one untimed bit from the released state
    task automatic configure(input logic [31:0] w, input int coef);
        @(negedge clk);
        enable      = 1'b0;
        timing_word = w;
        filt_len    = 5'(coef);
        @(negedge clk);
        // R10 lines released while disabled
        chk(!scl_drive_low && !sda_drive_low, "R10 disabled release", int'(scl_drive_low), 0);
        enable = 1'b1;
        idle(30);
        bit_go = 1'b1; tx_bit = 1'b1;
        @(negedge clk);
        bit_go = 1'b0;
        for (int i = 0; i < 12000 && !bit_done; i++) @(negedge clk);
        chk(bit_done == 1'b1, "R9 warm bit done", int'(bit_done), 1);
        last_tx = 1'b1;
        idle(40);
    endtask

    task automatic run_bit(input int d, input int s, input int h, input int hi, input int lo,
                           input int coef, input bit tx, input int x, input bit sl_sda,
                           input bit extra_go);
        int hs, ss, ls, hh, m, e_sda, e_rel, e_rx, e_end;
        int n, n_sda, n_rel, n_rx, n_end, rxv;
        bit prev_sda, st_seen, ended, sda_chg;
        hs = f_hold(h, d); ss = (s + 1) * (d + 1); ls = f_low(lo, d);
        hh = f_low(hi, d); m = f_m(coef);
        e_sda = 1 + hs;
        e_rel = 1 + f_max(ls, hs + ss);
        e_rx  = e_rel + x + 3 + m;
        e_end = e_rx + hh;
        n_sda = -1; n_rel = -1; n_rx = -1; n_end = -1; rxv = -1;
        st_seen = 1'b0; ended = 1'b0;
        sda_chg = (tx != last_tx);
        slave_scl_low = (x > 0);
        slave_sda_low = sl_sda;
        @(negedge clk);
        prev_sda = sda_drive_low;
        bit_go = 1'b1; tx_bit = tx;
        @(posedge clk);
        @(negedge clk);
        bit_go = 1'b0;
        n = 0;
        while (n < 12000 && !ended) begin
            if (n_sda < 0 && sda_drive_low != prev_sda) n_sda = n;
            if (n_rel < 0 && !scl_drive_low) n_rel = n;
            if (n_rel >= 0 && x > 0 && n == n_rel + x) slave_scl_low = 1'b0;
            if (extra_go && n_rel >= 0 && n == n_rel + 1) bit_go = 1'b1;
            else bit_go = 1'b0;
            if (stretch_seen) st_seen = 1'b1;
            if (rx_sample && n_rx < 0) begin n_rx = n; rxv = int'(rx_bit); end
            if (n_rel >= 0 && n > n_rel && scl_drive_low) begin
                n_end = n; ended = 1'b1;
                // R9 done pulse together with SCL pulled again
                chk(bit_done == 1'b1, "R9 bit_done at end", int'(bit_done), 1);
            end
            if (!ended) begin @(negedge clk); n++; end
        end
        bit_go = 1'b0;
        slave_sda_low = 1'b0;
        slave_scl_low = 1'b0;
        if (sda_chg) begin
            // R3 hold span
            chk(n_sda == e_sda, "R3 hold span", n_sda, e_sda);
        end
        // R2 / R4 low span including setup
        chk(n_rel == e_rel, "R2/R4 release time", n_rel, e_rel);
        // R8 sample time and value
        chk(n_rx == e_rx, "R8 sample time", n_rx, e_rx);
        chk(rxv == int'(tx & ~sl_sda), "R8 sampled level", rxv, int'(tx & ~sl_sda));
        // R5 high span (R6 via filter delay m)
        chk(n_end == e_end, "R5 high end", n_end, e_end);
        // R7 stretch flag
        chk(st_seen == (x > 0), "R7 stretch flag", int'(st_seen), int'(x > 0));
        last_tx = tx;
        @(negedge clk);
        chk(bit_done == 1'b0, "R9 done single pulse", int'(bit_done), 0);
        idle(40);
    endtask

    initial begin
        int d, s, h, hi, lo, c;
        logic [31:0] w;
        void'($urandom(32'h1c5e_ed01));
        idle(4);
        // R10 reset state
        chk(!scl_drive_low && !sda_drive_low && !rx_sample && !bit_done && !stretch_seen,
            "R10 reset outputs", int'(scl_drive_low | sda_drive_low | rx_sample | bit_done), 0);
        rst = 1'b0;
        idle(3);
        chk(!scl_drive_low && !sda_drive_low, "R10 idle after reset", int'(scl_drive_low), 0);

        // minimum fields, filter bypassed (R6)
        configure(f_pack(0, 0, 0, 0, 0, 0), 0);
        run_bit(0, 0, 0, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0);
        run_bit(0, 0, 0, 0, 0, 0, 1'b1, 0, 1'b0, 1'b0);

        // hold plus setup longer than low period, junk in ignored bits (R1)
        configure(f_pack(2, 9, 12, 3, 2, 15), 3);
        run_bit(2, 9, 12, 3, 2, 3, 1'b0, 0, 1'b0, 1'b0);

        // filter length above the ceiling is clamped (R6)
        configure(f_pack(1, 2, 3, 20, 30, 0), 22);
        run_bit(1, 2, 3, 20, 30, 22, 1'b1, 0, 1'b0, 1'b0);

        // clock stretching by the slave (R7)
        configure(f_pack(1, 1, 1, 5, 10, 0), 4);
        run_bit(1, 1, 1, 5, 10, 4, 1'b0, 25, 1'b0, 1'b0);
        // read bit: slave pulls SDA low (R8)
        run_bit(1, 1, 1, 5, 10, 4, 1'b1, 0, 1'b1, 1'b0);

        // request during a bit is ignored (R11)
        run_bit(1, 1, 1, 5, 10, 4, 1'b0, 0, 1'b0, 1'b1);
        begin
            bit spurious;
            spurious = 1'b0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (rx_sample || bit_done || !scl_drive_low) spurious = 1'b1;
            end
            chk(!spurious, "R11 extra request ignored", int'(spurious), 0);
        end

        // timing change while enabled has no effect (R1)
        timing_word = f_pack(3, 7, 7, 40, 40, 0);
        filt_len = 5'd9;
        idle(3);
        run_bit(1, 1, 1, 5, 10, 4, 1'b1, 0, 1'b0, 1'b0);
        configure(f_pack(3, 7, 7, 40, 40, 0), 9);
        run_bit(3, 7, 7, 40, 40, 9, 1'b0, 0, 1'b0, 1'b0);

        // random configurations
        for (int k = 0; k < 20; k++) begin
            d  = int'($urandom_range(0, 3));
            s  = int'($urandom_range(0, 15));
            h  = int'($urandom_range(0, 15));
            hi = int'($urandom_range(0, 40));
            lo = int'($urandom_range(0, 40));
            c  = int'($urandom_range(0, 18));
            w  = f_pack(d, s, h, hi, lo, int'($urandom_range(0, 15)));
            configure(w, c);
            run_bit(d, s, h, hi, lo, c, 1'b0, 0, 1'b0, 1'b0);
            run_bit(d, s, h, hi, lo, c, 1'b1, int'($urandom_range(0, 1)) * int'($urandom_range(1, 12)),
                    1'b0, 1'b0);
        end

        // disabling releases both lines (R10)
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(!scl_drive_low && !sda_drive_low, "R10 release on disable", int'(scl_drive_low), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule